// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller decides which operating mode a small microcontroller-style system is in. Software first loads a five-bit policy word that names a target mode (RUN, SLEEP, STOP, STANDBY or SHUTDOWN) and a sub-level within it. A wait-for-interrupt or wait-for-event strobe from the CPU then moves the system into that mode. From the current mode and sub-level the block derives a set of enables and selects:
- the CPU clock gate;
- the high-performance and low-speed power domains;
- the core regulator;
- the fast oscillator on/off and its 4 MHz gear;
- the 32 kHz limits on the main and peripheral clocks;
- per-peripheral clock feeds for the low-speed domain.

A pending interrupt brings the system back to RUN from SLEEP, STOP or STANDBY. SHUTDOWN works one way only. An I/O level match or a debug wake does not resume execution. Instead it raises a held request for a full brownout-level reset, and the controller stays in SHUTDOWN until its reset input is applied.

A peripheral can also raise an asynchronous fast-clock request while the system sleeps. The block synchronises this request and lifts every clock limit of the current low-power mode until the request drops. It does not touch the CPU clock or the domain enables, and it does not wake the CPU.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the mode is RUN (code 0) with the CPU clock, both domains, the regulator and the RTC clock enabled, pol_err and bor_req low, the fast oscillator on at full speed, no clock limit, and policy RUN sub-level 0 (word 0).
- R2: The policy word carries the mode code in bits [4:2] (0 RUN, 1 SLEEP, 2 STOP, 3 STANDBY, 4 SHUTDOWN) and the sub-level in bits [1:0]. The legal sub-levels are 0..2 for RUN, SLEEP and STOP, 0..1 for STANDBY and 0 for SHUTDOWN. A mode code of 5..7 is stored as SHUTDOWN sub-level 0. A sub-level above the maximum is stored as that mode's highest sub-level. pol_err is 1 after an illegal write and 0 after a legal one.
- R3: A wfi or wfe strobe in RUN with no interrupt pending moves the mode to the policy mode at the next edge. A RUN policy leaves the mode in RUN. Strobes outside RUN have no effect.
- R4: A strobe that arrives while irq is high leaves the mode in RUN.
- R5: The CPU clock is enabled only in RUN. The high-performance domain is enabled only in RUN and SLEEP. The low-speed domain, the regulator and the RTC clock are enabled in every mode except SHUTDOWN, where all outputs are 0.
- R6: In RUN and SLEEP, sub-level 0 gives the oscillator on with no limits. Sub-level 1 keeps the oscillator on and limits the main and peripheral clocks to 32 kHz. Sub-level 2 also turns the oscillator off. In RUN these sub-levels apply when the policy mode is RUN or SLEEP; otherwise RUN uses sub-level 0.
- R7: STOP sub-level 0 keeps the oscillator on at full speed. Sub-level 1 selects the 4 MHz gear. Sub-level 2 turns the oscillator off and limits the peripheral clock to 32 kHz. The main-clock limit is 0 in STOP.
- R8: STANDBY turns the oscillator off and limits the peripheral clock. Sub-level 0 feeds all peripheral clocks. Sub-level 1 feeds only the timers in TIMER_MASK (bits 0 and 1 by default).
- R9: irq high in SLEEP, STOP or STANDBY returns the mode to RUN at the next edge.
- R10: In SHUTDOWN, irq and the fast-clock request are ignored. io_wake or dbg_wake sets bor_req, which stays set, and the mode stays SHUTDOWN until rst_n.
- R11: A fast-clock request held in SLEEP, STOP or STANDBY raises boost_o exactly SYNC_STAGES+1 edges after it is applied. While boost_o is high the oscillator is on at full gear, no clock is limited and all peripheral clocks are fed. The mode and the domain enables are unchanged.
- R12: When the request drops, boost_o falls SYNC_STAGES+1 edges later and the mode stays in its low-power setting unless irq is high.
- R13: A policy write in the same cycle as a strobe does not affect that strobe; the strobe uses the previously stored policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_we | input | 1 | Policy write enable |
| pol_wdata | input | 5 | Policy word {mode[2:0], sub[1:0]} |
| wfi | input | 1 | Wait-for-interrupt strobe |
| wfe | input | 1 | Wait-for-event strobe |
| irq | input | 1 | Pending peripheral interrupt (level) |
| io_wake | input | 1 | I/O level-match wake from SHUTDOWN |
| dbg_wake | input | 1 | Debug-port wake from SHUTDOWN |
| fclk_req | input | 1 | Asynchronous fast-clock request |
| mode_o | output | 3 | Current mode code |
| pol_err | output | 1 | Last policy write was illegal |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| hp_dom_en | output | 1 | High-performance domain power enable |
| lp_dom_en | output | 1 | Low-speed domain power enable |
| core_reg_en | output | 1 | Core regulator enable |
| rtc_clk_en | output | 1 | RTC clock enable |
| fastosc_en | output | 1 | Fast oscillator enable |
| osc_gear_4m | output | 1 | Fast oscillator shifted to 4 MHz |
| main_clk_slow | output | 1 | Main clock limited to 32 kHz |
| periph_clk_slow | output | 1 | Low-power peripheral clock limited to 32 kHz |
| lp_clk_en | output | 8 | Per-peripheral clock feed in the low-speed domain |
| boost_o | output | 1 | Fast-clock request being served |
| bor_req | output | 1 | Brownout-level reset request after SHUTDOWN wake |

## Verification
The bench walks all 32 policy words and covers the behaviour of each one:
- the legalised result and the error flag;
- entry by wfi or wfe;
- the exact output vector in the low-power mode;
- the fast-clock boost and its release;
- the wake back to RUN.

Several faults show up directly as wrong outputs:
- a clamp that mishandles mode codes 5..7 or a too-high STANDBY sub-level enters the wrong mode;
- a swapped sub-level decode gates the wrong oscillator or timer feeds;
- a design that woke the CPU when the request dropped would show RUN where the low-power mode is expected.

The boost is sampled one edge before and at its expected latency, so a missing or extra synchroniser stage is caught. Two more cases target mistakes that would let the system sleep when it should not: an interrupt pending at the strobe, and a write in the same cycle as the strobe. A SHUTDOWN that resumed to RUN, or that cleared its reset request early, fails the held-state checks.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
   localparam int MODE_W = 3;
   localparam int SUB_W  = 2;
   localparam int POL_W  = MODE_W + SUB_W;

   typedef enum logic [MODE_W-1:0] {
      PM_RUN     = 3'd0,
      PM_SLEEP   = 3'd1,
      PM_STOP    = 3'd2,
      PM_STANDBY = 3'd3,
      PM_OFF     = 3'd4
   } pm_mode_e;

   // highest legal sub-level of each mode (also its lowest-power setting)
   function automatic logic [SUB_W-1:0] top_sub(input pm_mode_e m);
      case (m)
         PM_RUN, PM_SLEEP, PM_STOP: top_sub = SUB_W'(2);
         PM_STANDBY:                top_sub = SUB_W'(1);
         default:                   top_sub = '0;
      endcase
   endfunction

   function automatic int ones64(input logic [63:0] v);
      int n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/lpm_policy_reg.sv
`timescale 1ns/1ps
module lpm_policy_reg
   import lpm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [POL_W-1:0] wdata,
   output pm_mode_e         pol_mode,
   output logic [SUB_W-1:0] pol_sub,
   output logic             pol_err
);
   logic [MODE_W-1:0] raw_m;
   logic [SUB_W-1:0]  raw_s;
   pm_mode_e          fix_m;
   logic [SUB_W-1:0]  fix_s;
   logic              bad;

   assign raw_m = wdata[POL_W-1:SUB_W];
   assign raw_s = wdata[SUB_W-1:0];

   // clamp toward the nearest lower-power legal setting
   always_comb begin
      bad   = 1'b0;
      fix_m = PM_OFF;
      fix_s = '0;
      if (raw_m > MODE_W'(PM_OFF)) begin
         bad = 1'b1;
      end else begin
         fix_m = pm_mode_e'(raw_m);
         if (raw_s > top_sub(fix_m)) begin
            fix_s = top_sub(fix_m);
            bad   = 1'b1;
         end else begin
            fix_s = raw_s;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_mode <= PM_RUN;
         pol_sub  <= '0;
         pol_err  <= 1'b0;
      end else if (we) begin
         pol_mode <= fix_m;
         pol_sub  <= fix_s;
         pol_err  <= bad;
      end
   end

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(pol_mode) && $stable(pol_sub) && $stable(pol_err))); // R2
   AST_POL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pol_sub <= top_sub(pol_mode)); // R2
endmodule

// File: rtl/lpm_req_sync.sv
`timescale 1ns/1ps
module lpm_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= async_in;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign sync_out = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lpm_mode_fsm.sv
`timescale 1ns/1ps
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  pm_mode_e         pol_mode,
   input  logic [SUB_W-1:0] pol_sub,
   input  logic             strobe,
   input  logic             irq,
   input  logic             off_wake,
   input  logic             boost_req,
   output pm_mode_e         mode_q,
   output logic [SUB_W-1:0] eff_sub,
   output logic             boost_q,
   output logic             bor_q
);
   pm_mode_e         mode_n;
   logic [SUB_W-1:0] sub_q, sub_n;
   logic             bor_n, boost_n;
   logic             lp_next;

   always_comb begin
      mode_n = mode_q;
      sub_n  = sub_q;
      bor_n  = bor_q;
      case (mode_q)
         PM_RUN: begin
            if (strobe && !irq && (pol_mode != PM_RUN)) begin
               mode_n = pol_mode;
               sub_n  = pol_sub;
            end
         end
         PM_SLEEP, PM_STOP, PM_STANDBY: begin
            if (irq) begin
               mode_n = PM_RUN;
               sub_n  = '0;
            end
         end
         default: begin
            if (off_wake) bor_n = 1'b1;
         end
      endcase
   end

   assign lp_next = (mode_n == PM_SLEEP) || (mode_n == PM_STOP) || (mode_n == PM_STANDBY);
   assign boost_n = boost_req && lp_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PM_RUN;
         sub_q   <= '0;
         bor_q   <= 1'b0;
         boost_q <= 1'b0;
      end else begin
         mode_q  <= mode_n;
         sub_q   <= sub_n;
         bor_q   <= bor_n;
         boost_q <= boost_n;
      end
   end

   // RUN follows the live policy sub-level when it names RUN or SLEEP
   always_comb begin
      if (mode_q == PM_RUN)
         eff_sub = ((pol_mode == PM_RUN) || (pol_mode == PM_SLEEP)) ? pol_sub : '0;
      else
         eff_sub = sub_q;
   end

   AST_IRQ_VETO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && strobe && irq) |=> (mode_q == PM_RUN)); // R4
   AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q inside {PM_SLEEP, PM_STOP, PM_STANDBY}) && irq) |=> (mode_q == PM_RUN)); // R9
   AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_OFF) |=> (mode_q == PM_OFF)); // R10
   AST_BOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bor_q |=> bor_q); // R10
   AST_BOR_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      bor_q |-> (mode_q == PM_OFF)); // R10
   AST_BOOST_LP: assert property (@(posedge clk) disable iff (!rst_n)
      boost_q |-> (mode_q inside {PM_SLEEP, PM_STOP, PM_STANDBY})); // R11
   AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_RUN && !irq) |=> (mode_q == $past(mode_q))); // R12
endmodule

// File: rtl/lpm_out_map.sv
`timescale 1ns/1ps
module lpm_out_map
   import lpm_pkg::*;
#(
   parameter int                  N_PERIPH   = 8,
   parameter logic [N_PERIPH-1:0] TIMER_MASK = N_PERIPH'(3)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  pm_mode_e            mode,
   input  logic [SUB_W-1:0]    sub,
   input  logic                boost,
   output logic                cpu_clk_en,
   output logic                hp_dom_en,
   output logic                lp_dom_en,
   output logic                core_reg_en,
   output logic                rtc_clk_en,
   output logic                fastosc_en,
   output logic                osc_gear_4m,
   output logic                main_clk_slow,
   output logic                periph_clk_slow,
   output logic [N_PERIPH-1:0] lp_clk_en
);
   logic feed_all, feed_tim;
   logic base_osc, base_gear, base_mslow, base_pslow, base_all;

   assign cpu_clk_en  = (mode == PM_RUN);
   assign hp_dom_en   = (mode == PM_RUN) || (mode == PM_SLEEP);
   assign lp_dom_en   = (mode != PM_OFF);
   assign core_reg_en = (mode != PM_OFF);
   assign rtc_clk_en  = (mode != PM_OFF);

   always_comb begin
      base_osc   = 1'b0;
      base_gear  = 1'b0;
      base_mslow = 1'b0;
      base_pslow = 1'b0;
      base_all   = 1'b0;
      feed_tim   = 1'b0;
      case (mode)
         PM_RUN, PM_SLEEP: begin
            base_osc   = (sub != SUB_W'(2));
            base_mslow = (sub != '0);
            base_pslow = (sub != '0);
            base_all   = 1'b1;
         end
         PM_STOP: begin
            base_osc   = (sub != SUB_W'(2));
            base_gear  = (sub == SUB_W'(1));
            base_pslow = (sub == SUB_W'(2));
            base_all   = 1'b1;
         end
         PM_STANDBY: begin
            base_pslow = 1'b1;
            base_all   = (sub == '0);
            feed_tim   = 1'b1;
         end
         default: ;
      endcase
   end

   // a served fast-clock request lifts every limit of the low-power mode
   assign fastosc_en      = boost ? 1'b1 : base_osc;
   assign osc_gear_4m     = boost ? 1'b0 : base_gear;
   assign main_clk_slow   = boost ? 1'b0 : base_mslow;
   assign periph_clk_slow = boost ? 1'b0 : base_pslow;
   assign feed_all        = boost | base_all;

   generate
      for (genvar g = 0; g < N_PERIPH; g++) begin : g_pclk
         if (TIMER_MASK[g]) begin : g_tim
            assign lp_clk_en[g] = feed_all | feed_tim;
         end else begin : g_plain
            assign lp_clk_en[g] = feed_all;
         end
      end
   endgenerate

   AST_CPU_NEEDS_HP: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> hp_dom_en); // R5
   AST_HP_NEEDS_LP: assert property (@(posedge clk) disable iff (!rst_n)
      hp_dom_en |-> (lp_dom_en && core_reg_en)); // R5
   AST_GEAR_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      osc_gear_4m |-> fastosc_en); // R7
endmodule

// File: rtl/lpm_seq_ctrl.sv
`timescale 1ns/1ps
module lpm_seq_ctrl
   import lpm_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  N_PERIPH    = 8,
   parameter logic [N_PERIPH-1:0] TIMER_MASK  = N_PERIPH'(3)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pol_we,
   input  logic [POL_W-1:0]    pol_wdata,
   input  logic                wfi,
   input  logic                wfe,
   input  logic                irq,
   input  logic                io_wake,
   input  logic                dbg_wake,
   input  logic                fclk_req,
   output logic [MODE_W-1:0]   mode_o,
   output logic                pol_err,
   output logic                cpu_clk_en,
   output logic                hp_dom_en,
   output logic                lp_dom_en,
   output logic                core_reg_en,
   output logic                rtc_clk_en,
   output logic                fastosc_en,
   output logic                osc_gear_4m,
   output logic                main_clk_slow,
   output logic                periph_clk_slow,
   output logic [N_PERIPH-1:0] lp_clk_en,
   output logic                boost_o,
   output logic                bor_req
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
      if (N_PERIPH < 2 || N_PERIPH > 64) begin : g_bad_np
         $error("N_PERIPH must be within 2..64");
      end
      if (ones64(64'(TIMER_MASK)) != 2) begin : g_bad_mask
         $error("TIMER_MASK must select exactly two timers");
      end
   endgenerate

   pm_mode_e         pol_mode, mode_q;
   logic [SUB_W-1:0] pol_sub, eff_sub;
   logic             req_s;

   lpm_policy_reg u_pol (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (pol_we),
      .wdata    (pol_wdata),
      .pol_mode (pol_mode),
      .pol_sub  (pol_sub),
      .pol_err  (pol_err)
   );

   lpm_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (fclk_req),
      .sync_out (req_s)
   );

   lpm_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol_mode  (pol_mode),
      .pol_sub   (pol_sub),
      .strobe    (wfi | wfe),
      .irq       (irq),
      .off_wake  (io_wake | dbg_wake),
      .boost_req (req_s),
      .mode_q    (mode_q),
      .eff_sub   (eff_sub),
      .boost_q   (boost_o),
      .bor_q     (bor_req)
   );

   lpm_out_map #(.N_PERIPH(N_PERIPH), .TIMER_MASK(TIMER_MASK)) u_map (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode            (mode_q),
      .sub             (eff_sub),
      .boost           (boost_o),
      .cpu_clk_en      (cpu_clk_en),
      .hp_dom_en       (hp_dom_en),
      .lp_dom_en       (lp_dom_en),
      .core_reg_en     (core_reg_en),
      .rtc_clk_en      (rtc_clk_en),
      .fastosc_en      (fastosc_en),
      .osc_gear_4m     (osc_gear_4m),
      .main_clk_slow   (main_clk_slow),
      .periph_clk_slow (periph_clk_slow),
      .lp_clk_en       (lp_clk_en)
   );

   assign mode_o = mode_q;
endmodule

// File: tb/lpm_seq_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_seq_ctrl_tb_top;
   localparam int SYNC = 2;
   localparam int NP   = 8;
   localparam logic [NP-1:0] TMASK = 8'h03;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pol_we = 1'b0, wfi = 1'b0, wfe = 1'b0, irq = 1'b0;
   logic io_wake = 1'b0, dbg_wake = 1'b0, fclk_req = 1'b0;
   logic [4:0] pol_wdata = '0;
   logic [2:0] mode_o;
   logic pol_err, cpu_clk_en, hp_dom_en, lp_dom_en, core_reg_en, rtc_clk_en;
   logic fastosc_en, osc_gear_4m, main_clk_slow, periph_clk_slow, boost_o, bor_req;
   logic [NP-1:0] lp_clk_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lpm_seq_ctrl #(.SYNC_STAGES(SYNC), .N_PERIPH(NP), .TIMER_MASK(TMASK)) dut_i (
      .clk(clk), .rst_n(rst_n), .pol_we(pol_we), .pol_wdata(pol_wdata),
      .wfi(wfi), .wfe(wfe), .irq(irq), .io_wake(io_wake), .dbg_wake(dbg_wake),
      .fclk_req(fclk_req), .mode_o(mode_o), .pol_err(pol_err),
      .cpu_clk_en(cpu_clk_en), .hp_dom_en(hp_dom_en), .lp_dom_en(lp_dom_en),
      .core_reg_en(core_reg_en), .rtc_clk_en(rtc_clk_en), .fastosc_en(fastosc_en),
      .osc_gear_4m(osc_gear_4m), .main_clk_slow(main_clk_slow),
      .periph_clk_slow(periph_clk_slow), .lp_clk_en(lp_clk_en),
      .boost_o(boost_o), .bor_req(bor_req)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] dom_vec();
      return {cpu_clk_en, hp_dom_en, lp_dom_en, core_reg_en, rtc_clk_en};
   endfunction

   function automatic logic [11:0] clk_vec();
      return {fastosc_en, osc_gear_4m, main_clk_slow, periph_clk_slow, lp_clk_en};
   endfunction

   // expected domain bits: cpu, hp, lp, regulator, rtc
   function automatic logic [4:0] exp_dom(input int m);
      logic on;
      on = (m != 4);
      return {m == 0, m <= 1, on, on, on};
   endfunction

   // expected clock bits: osc, gear, main slow, periph slow, feeds
   function automatic logic [11:0] exp_clk(input int m, input int s, input bit b);
      logic o, g, ms, ps;
      logic [NP-1:0] f;
      o = 0; g = 0; ms = 0; ps = 0; f = '0;
      if (m <= 1) begin
         o = (s < 2); ms = (s > 0); ps = (s > 0); f = '1;
      end else if (m == 2) begin
         o = (s < 2); g = (s == 1); ps = (s == 2); f = '1;
      end else if (m == 3) begin
         ps = 1; f = (s == 0) ? '1 : TMASK;
      end
      if (b && m >= 1 && m <= 3) begin
         o = 1; g = 0; ms = 0; ps = 0; f = '1;
      end
      return {o, g, ms, ps, f};
   endfunction

   function automatic string clk_tag(input int m);
      if (m <= 1) return "R6 run/sleep clocks";
      if (m == 2) return "R7 stop clocks";
      if (m == 3) return "R8 standby feeds";
      return "R10 shutdown clocks";
   endfunction

   task automatic do_reset();
      rst_n = 0; pol_we = 0; wfi = 0; wfe = 0; irq = 0;
      io_wake = 0; dbg_wake = 0; fclk_req = 0; pol_wdata = '0;
      tick(2);
      rst_n = 1;
      tick(1);
   endtask

   task automatic write_pol(input logic [4:0] w);
      pol_we = 1; pol_wdata = w;
      tick(1);
      pol_we = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      do_reset();
      for (int code = 0; code < 32; code++) begin
         int bm, bs, m, s, lim, rs;
         bit err;
         bm = code >> 2; bs = code & 3; err = 0;
         if (bm > 4) begin m = 4; s = 0; err = 1; end
         else begin
            m = bm;
            lim = (bm == 3) ? 1 : (bm == 4) ? 0 : 2;
            if (bs > lim) begin s = lim; err = 1; end else s = bs;
         end
         rs = (m <= 1) ? s : 0;

         do_reset();
         // R1 reset state
         chk("R1 reset mode", 32'(mode_o), 0);
         chk("R1 reset flags", {pol_err, bor_req, boost_o}, 0);
         chk("R1 reset domains", 32'(dom_vec()), 32'(exp_dom(0)));
         chk("R1 reset clocks", 32'(clk_vec()), 32'(exp_clk(0, 0, 0)));

         write_pol(5'(code));
         chk("R2 error flag", 32'(pol_err), 32'(err));
         chk("R6 run clocks under policy", 32'(clk_vec()), 32'(exp_clk(0, rs, 0)));

         if (code[0]) wfe = 1; else wfi = 1;
         tick(1);
         wfi = 0; wfe = 0;
         chk("R3 entry mode", 32'(mode_o), 32'(m));
         chk("R5 domains", 32'(dom_vec()), 32'(exp_dom(m)));
         chk(clk_tag(m), 32'(clk_vec()), 32'(exp_clk(m, (m == 0) ? rs : s, 0)));

         if (m >= 1 && m <= 3) begin
            wfi = 1; tick(1); wfi = 0;
            chk("R3 strobe ignored outside RUN", 32'(mode_o), 32'(m));
            fclk_req = 1;
            tick(SYNC);
            chk("R11 boost latency early", 32'(boost_o), 0);
            tick(1);
            chk("R11 boost set", 32'(boost_o), 1);
            chk("R11 boost mode kept", 32'(mode_o), 32'(m));
            chk("R11 boost domains", 32'(dom_vec()), 32'(exp_dom(m)));
            chk("R11 boost clocks", 32'(clk_vec()), 32'(exp_clk(m, s, 1)));
            fclk_req = 0;
            tick(SYNC);
            chk("R12 boost still held", 32'(boost_o), 1);
            tick(1);
            chk("R12 boost released", 32'(boost_o), 0);
            chk("R12 no wake", 32'(mode_o), 32'(m));
            chk("R12 clocks restored", 32'(clk_vec()), 32'(exp_clk(m, s, 0)));
            irq = 1; tick(1); irq = 0;
            chk("R9 wake mode", 32'(mode_o), 0);
            chk("R9 wake domains", 32'(dom_vec()), 32'(exp_dom(0)));
            chk("R9 wake clocks", 32'(clk_vec()), 32'(exp_clk(0, (m == 1) ? s : 0, 0)));
         end else if (m == 4) begin
            irq = 1; fclk_req = 1;
            tick(SYNC + 2);
            irq = 0; fclk_req = 0;
            chk("R10 irq ignored", 32'(mode_o), 4);
            chk("R10 request ignored", 32'(boost_o), 0);
            chk("R10 no early reset request", 32'(bor_req), 0);
            if (code[0]) dbg_wake = 1; else io_wake = 1;
            tick(1);
            io_wake = 0; dbg_wake = 0;
            chk("R10 reset request", 32'(bor_req), 1);
            tick(3);
            chk("R10 reset request held", 32'(bor_req), 1);
            chk("R10 stays off", 32'(mode_o), 4);
            chk("R10 outputs off", 32'({dom_vec(), clk_vec()}), 0);
         end
      end

      // R4: interrupt pending at the strobe blocks entry
      do_reset();
      write_pol(5'b00100);
      irq = 1; wfi = 1; tick(1); irq = 0; wfi = 0;
      chk("R4 irq veto", 32'(mode_o), 0);
      wfi = 1; tick(1); wfi = 0;
      chk("R4 later entry", 32'(mode_o), 1);

      // R13: same-cycle write uses the old policy
      do_reset();
      pol_we = 1; pol_wdata = 5'b01000; wfe = 1;
      tick(1);
      pol_we = 0; wfe = 0;
      chk("R13 old policy used", 32'(mode_o), 0);
      wfe = 1; tick(1); wfe = 0;
      chk("R13 new policy next", 32'(mode_o), 2);

      // R11: request raised while in RUN has no effect on RUN clocks
      do_reset();
      fclk_req = 1; tick(SYNC + 2);
      chk("R11 ignored in RUN", 32'(boost_o), 0);
      fclk_req = 0;

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule